// File: doc/BRIEF.md
# Sub-Pixel Clock Edge Generator

This block produces the fast drive clocks and sampling strobes for an image-sensor readout chain. It runs on a fast clock at 48 times the pixel rate. A free-running phase counter steps through the 48 sub-pixel positions of every pixel period and wraps back to zero. The counter's zero position lines up with the start of each pixel period.

Three level outputs are built from programmed positions: a reset-gate clock and two horizontal clocks. Each has a rising-position code, a falling-position code and an invert control. Each horizontal clock also drives a companion output that is always its complement. Two sampling strobes, one for the reference level and one for the data level, each fire once per pixel period at their own programmed position.

Every position code is 6 bits wide. The upper 2 bits pick one of four quadrants of 12 positions, and the lower 4 bits pick the slot inside that quadrant. A code whose slot field is 12 to 15 names no position. The programming inputs are plain parallel ports, and they may change at any fast-clock edge.

Top module: `sub_pixel_edge_gen`

## Requirements
- R1: `phaseOut` counts 0,1,...,47 and then returns to 0, advancing by one on each fast-clock edge while `rstN` is high.
- R2: A position code maps to the position 12*code[5:4] + code[3:0]. The internal level of a channel becomes 1 on the edge that follows a cycle in which `phaseOut` equals its decoded rising position, so the output changes one cycle after the match.
- R3: The internal level of a channel becomes 0 on the edge that follows a cycle in which `phaseOut` equals its decoded falling position.
- R4: A code with code[3:0] in 12..15 is invalid and produces no edge. A channel whose rising and falling codes are both invalid keeps its level.
- R5: When the rising and falling codes of a channel decode to the same valid position, the level keeps its previous value at that match.
- R6: Each level output equals the internal level XOR its invert input (1 = inverted). The invert input acts combinationally, without a cycle of delay.
- R7: `hAnOut` is always the complement of `hAOut`, and `hBnOut` is always the complement of `hBOut`.
- R8: `sampRefStrobe` (and `sampDataStrobe`) is high for exactly the one cycle that follows a cycle in which `phaseOut` equals the strobe's decoded valid position. It is low in every other cycle, and it never fires for an invalid code.
- R9: A synchronous reset (`rstN` low at a clock edge) sets `phaseOut` to 0, clears all internal levels and clears both strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 cycles per pixel period |
| rstN | input | 1 | Synchronous reset, active low |
| rgRiseCode | input | 6 | Reset-gate rising position code |
| rgFallCode | input | 6 | Reset-gate falling position code |
| rgInvert | input | 1 | Reset-gate polarity invert |
| hARiseCode | input | 6 | Horizontal clock A rising position code |
| hAFallCode | input | 6 | Horizontal clock A falling position code |
| hAInvert | input | 1 | Horizontal clock A polarity invert |
| hBRiseCode | input | 6 | Horizontal clock B rising position code |
| hBFallCode | input | 6 | Horizontal clock B falling position code |
| hBInvert | input | 1 | Horizontal clock B polarity invert |
| sampRefCode | input | 6 | Reference-level strobe position code |
| sampDataCode | input | 6 | Data-level strobe position code |
| phaseOut | output | 6 | Current sub-pixel position 0..47 |
| rgOut | output | 1 | Reset-gate clock |
| hAOut | output | 1 | Horizontal clock A |
| hAnOut | output | 1 | Complement of horizontal clock A |
| hBOut | output | 1 | Horizontal clock B |
| hBnOut | output | 1 | Complement of horizontal clock B |
| sampRefStrobe | output | 1 | Reference-level sampling strobe |
| sampDataStrobe | output | 1 | Data-level sampling strobe |

## Verification
Every one of the 64 rising codes is paired with sixteen falling codes spread around the period. Both the reset-gate and horizontal channels are driven this way, and the strobes are driven from the same codes. This separates the quadrant and slot arithmetic, the wrap at position 47, and the handling of invalid slot values. A second sweep programs equal rising and falling codes on top of a known level, which tells holding the level apart from giving priority to either edge. The invert bits change with the sweep index, so polarity is exercised on both internal levels. The complement outputs and the strobe positions are compared against a cycle-stepped arithmetic model on every fast-clock cycle.

// File: rtl/sp_edge_pkg.sv
package sp_edge_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_RG  = 0;
  localparam int CH_HA  = 1;
  localparam int CH_HB  = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] setHit;
    logic [NUM_CH-1:0] clrHit;
    logic              refHit;
    logic              dataHit;
  } edge_strobes_t;
endpackage

// File: rtl/sp_code_decode.sv
module sp_code_decode #(
  parameter int QUAD_W = 2,
  parameter int SLOT_W = 4,
  parameter int SLOTS  = 12,
  parameter int POS_W  = 6
) (
  input  logic [QUAD_W+SLOT_W-1:0] code,
  output logic [POS_W-1:0]         pos,
  output logic                     valid
);
  logic [QUAD_W-1:0] quad;
  logic [SLOT_W-1:0] slot;

  assign quad  = code[QUAD_W+SLOT_W-1:SLOT_W];
  assign slot  = code[SLOT_W-1:0];
  assign valid = (int'(slot) < SLOTS);
  assign pos   = POS_W'(quad) * POS_W'(SLOTS) + POS_W'(slot);
endmodule

// File: rtl/sp_phase_ctrl.sv
module sp_phase_ctrl
  import sp_edge_pkg::*;
#(
  parameter int QUAD_W  = 2,
  parameter int SLOT_W  = 4,
  parameter int SLOTS   = 12,
  parameter int NUM_POS = 48,
  parameter int PHASE_W = 6
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_CH-1:0][QUAD_W+SLOT_W-1:0] riseCode,
  input  logic [NUM_CH-1:0][QUAD_W+SLOT_W-1:0] fallCode,
  input  logic [QUAD_W+SLOT_W-1:0]             refCode,
  input  logic [QUAD_W+SLOT_W-1:0]             dataCode,
  output logic [PHASE_W-1:0]                   phase,
  output edge_strobes_t                        strobes
);
  localparam logic [PHASE_W-1:0] LAST_POS = PHASE_W'(NUM_POS - 1);

  logic [NUM_CH-1:0] setVec;
  logic [NUM_CH-1:0] clrVec;
  logic [PHASE_W-1:0] refPos, dataPos;
  logic refValid, dataValid;

  always_ff @(posedge clk) begin
    if (!rstN)                 phase <= '0;
    else if (phase == LAST_POS) phase <= '0;
    else                       phase <= phase + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [PHASE_W-1:0] risePos, fallPos;
    logic riseValid, fallValid;

    sp_code_decode #(.QUAD_W(QUAD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .POS_W(PHASE_W))
      u_riseDec (.code(riseCode[g]), .pos(risePos), .valid(riseValid));
    sp_code_decode #(.QUAD_W(QUAD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .POS_W(PHASE_W))
      u_fallDec (.code(fallCode[g]), .pos(fallPos), .valid(fallValid));

    assign setVec[g] = riseValid && (risePos == phase);
    assign clrVec[g] = fallValid && (fallPos == phase);
  end

  sp_code_decode #(.QUAD_W(QUAD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .POS_W(PHASE_W))
    u_refDec (.code(refCode), .pos(refPos), .valid(refValid));
  sp_code_decode #(.QUAD_W(QUAD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS), .POS_W(PHASE_W))
    u_dataDec (.code(dataCode), .pos(dataPos), .valid(dataValid));

  always_comb begin
    strobes.setHit  = setVec;
    strobes.clrHit  = clrVec;
    strobes.refHit  = refValid && (refPos == phase);
    strobes.dataHit = dataValid && (dataPos == phase);
  end
endmodule

// File: rtl/sp_edge_datapath.sv
module sp_edge_datapath
  import sp_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  edge_strobes_t     strobes,
  input  logic [NUM_CH-1:0] invert,
  output logic [NUM_CH-1:0] chOut,
  output logic              refStrobe,
  output logic              dataStrobe
);
  logic [NUM_CH-1:0] level;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level      <= '0;
      refStrobe  <= 1'b0;
      dataStrobe <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (strobes.setHit[i] && !strobes.clrHit[i])      level[i] <= 1'b1;
        else if (strobes.clrHit[i] && !strobes.setHit[i]) level[i] <= 1'b0;
      end
      refStrobe  <= strobes.refHit;
      dataStrobe <= strobes.dataHit;
    end
  end

  assign chOut = level ^ invert;
endmodule

// File: rtl/sub_pixel_edge_gen.sv
module sub_pixel_edge_gen
  import sp_edge_pkg::*;
#(
  parameter int QUAD_W  = 2,
  parameter int SLOT_W  = 4,
  parameter int SLOTS   = 12,
  parameter int NUM_POS = SLOTS * (2 ** QUAD_W),
  parameter int PHASE_W = $clog2(NUM_POS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [QUAD_W+SLOT_W-1:0] rgRiseCode,
  input  logic [QUAD_W+SLOT_W-1:0] rgFallCode,
  input  logic                     rgInvert,
  input  logic [QUAD_W+SLOT_W-1:0] hARiseCode,
  input  logic [QUAD_W+SLOT_W-1:0] hAFallCode,
  input  logic                     hAInvert,
  input  logic [QUAD_W+SLOT_W-1:0] hBRiseCode,
  input  logic [QUAD_W+SLOT_W-1:0] hBFallCode,
  input  logic                     hBInvert,
  input  logic [QUAD_W+SLOT_W-1:0] sampRefCode,
  input  logic [QUAD_W+SLOT_W-1:0] sampDataCode,
  output logic [PHASE_W-1:0]       phaseOut,
  output logic                     rgOut,
  output logic                     hAOut,
  output logic                     hAnOut,
  output logic                     hBOut,
  output logic                     hBnOut,
  output logic                     sampRefStrobe,
  output logic                     sampDataStrobe
);
  localparam int CODE_W = QUAD_W + SLOT_W;

  logic [NUM_CH-1:0][CODE_W-1:0] riseCodes, fallCodes;
  logic [NUM_CH-1:0] invVec, chOut;
  edge_strobes_t strobes;

  always_comb begin
    riseCodes[CH_RG] = rgRiseCode;
    riseCodes[CH_HA] = hARiseCode;
    riseCodes[CH_HB] = hBRiseCode;
    fallCodes[CH_RG] = rgFallCode;
    fallCodes[CH_HA] = hAFallCode;
    fallCodes[CH_HB] = hBFallCode;
    invVec[CH_RG]    = rgInvert;
    invVec[CH_HA]    = hAInvert;
    invVec[CH_HB]    = hBInvert;
  end

  sp_phase_ctrl #(
    .QUAD_W(QUAD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS),
    .NUM_POS(NUM_POS), .PHASE_W(PHASE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .riseCode(riseCodes), .fallCode(fallCodes),
    .refCode(sampRefCode), .dataCode(sampDataCode),
    .phase(phaseOut), .strobes(strobes)
  );

  sp_edge_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .invert(invVec),
    .chOut(chOut), .refStrobe(sampRefStrobe), .dataStrobe(sampDataStrobe)
  );

  assign rgOut  = chOut[CH_RG];
  assign hAOut  = chOut[CH_HA];
  assign hAnOut = ~chOut[CH_HA];
  assign hBOut  = chOut[CH_HB];
  assign hBnOut = ~chOut[CH_HB];
endmodule

// File: rtl/sp_edge_gen_checker.sv
module sp_edge_gen_checker #(
  parameter int QUAD_W  = 2,
  parameter int SLOT_W  = 4,
  parameter int SLOTS   = 12,
  parameter int NUM_POS = 48,
  parameter int PHASE_W = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [PHASE_W-1:0]       phaseOut,
  input logic [QUAD_W+SLOT_W-1:0] rgRiseCode,
  input logic [QUAD_W+SLOT_W-1:0] rgFallCode,
  input logic                     rgInvert,
  input logic                     rgOut,
  input logic                     hAOut,
  input logic                     hAnOut,
  input logic                     hBOut,
  input logic                     hBnOut,
  input logic [QUAD_W+SLOT_W-1:0] sampRefCode,
  input logic                     sampRefStrobe
);
  localparam logic [PHASE_W-1:0] LAST_POS = PHASE_W'(NUM_POS - 1);

  function automatic logic isBad(input logic [QUAD_W+SLOT_W-1:0] c);
    return int'(c[SLOT_W-1:0]) >= SLOTS;
  endfunction

  function automatic int posOf(input logic [QUAD_W+SLOT_W-1:0] c);
    return int'(c[QUAD_W+SLOT_W-1:SLOT_W]) * SLOTS + int'(c[SLOT_W-1:0]);
  endfunction

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOut == LAST_POS) |=> (phaseOut == '0));

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (phaseOut != LAST_POS) |=> (phaseOut == $past(phaseOut) + 1'b1));

  assert_invalid_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isBad(rgRiseCode) && isBad(rgFallCode)) |=> (!$stable(rgInvert) || $stable(rgOut)));

  assert_equal_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rgRiseCode == rgFallCode) |=> (!$stable(rgInvert) || $stable(rgOut)));

  assert_comp_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    hAnOut != hAOut);

  assert_comp_b_R7: assert property (@(posedge clk) disable iff (!rstN)
    hBnOut != hBOut);

  assert_strobe_pos_R8: assert property (@(posedge clk) disable iff (!rstN)
    sampRefStrobe |-> (!isBad($past(sampRefCode)) &&
                       int'($past(phaseOut)) == posOf($past(sampRefCode))));
endmodule

bind sub_pixel_edge_gen sp_edge_gen_checker #(
  .QUAD_W(QUAD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS),
  .NUM_POS(NUM_POS), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .phaseOut(phaseOut),
  .rgRiseCode(rgRiseCode), .rgFallCode(rgFallCode), .rgInvert(rgInvert),
  .rgOut(rgOut), .hAOut(hAOut), .hAnOut(hAnOut), .hBOut(hBOut), .hBnOut(hBnOut),
  .sampRefCode(sampRefCode), .sampRefStrobe(sampRefStrobe)
);

// File: tb/sub_pixel_edge_gen_bench.sv
module sub_pixel_edge_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] rgRise = '0, rgFall = '0, hARise = '0, hAFall = '0, hBRise = '0, hBFall = '0;
  logic [5:0] refCode = '0, dataCode = '0;
  logic rgInv = 1'b0, hAInv = 1'b0, hBInv = 1'b0;
  logic [5:0] phaseOut;
  logic rgOut, hAOut, hAnOut, hBOut, hBnOut, refStb, dataStb;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // model state
  int mPhase = 0;
  bit mLvl [3];
  bit mRef = 0, mData = 0;

  always #5 clk = ~clk;

  sub_pixel_edge_gen u_sub_pixel_edge_gen (
    .clk(clk), .rstN(rstN),
    .rgRiseCode(rgRise), .rgFallCode(rgFall), .rgInvert(rgInv),
    .hARiseCode(hARise), .hAFallCode(hAFall), .hAInvert(hAInv),
    .hBRiseCode(hBRise), .hBFallCode(hBFall), .hBInvert(hBInv),
    .sampRefCode(refCode), .sampDataCode(dataCode),
    .phaseOut(phaseOut), .rgOut(rgOut), .hAOut(hAOut), .hAnOut(hAnOut),
    .hBOut(hBOut), .hBnOut(hBnOut),
    .sampRefStrobe(refStb), .sampDataStrobe(dataStb)
  );

  // position arithmetic from R2 / R4: 12*quadrant + slot, slot 12..15 invalid
  function automatic bit hitAt(input logic [5:0] c, input int ph);
    if (c[3:0] >= 4'd12) return 1'b0;
    return (int'(c[5:4]) * 12 + int'(c[3:0])) == ph;
  endfunction

  function automatic bit nextLvl(input bit cur, input bit s, input bit c);
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    return cur;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0;
      mLvl[0] = 0; mLvl[1] = 0; mLvl[2] = 0;
      mRef = 0; mData = 0;
    end else begin
      mLvl[0] = nextLvl(mLvl[0], hitAt(rgRise, mPhase), hitAt(rgFall, mPhase));
      mLvl[1] = nextLvl(mLvl[1], hitAt(hARise, mPhase), hitAt(hAFall, mPhase));
      mLvl[2] = nextLvl(mLvl[2], hitAt(hBRise, mPhase), hitAt(hBFall, mPhase));
      mRef  = hitAt(refCode, mPhase);
      mData = hitAt(dataCode, mPhase);
      mPhase = (mPhase == 47) ? 0 : mPhase + 1;
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R1", "phaseOut", int'(phaseOut), mPhase);
    chk("R2/R3/R4/R5/R6", "rgOut", int'(rgOut), int'(mLvl[0] ^ rgInv));
    chk("R2/R3/R4/R5/R6", "hAOut", int'(hAOut), int'(mLvl[1] ^ hAInv));
    chk("R2/R3/R4/R5/R6", "hBOut", int'(hBOut), int'(mLvl[2] ^ hBInv));
    chk("R7", "hAnOut", int'(hAnOut), int'(!(mLvl[1] ^ hAInv)));
    chk("R7", "hBnOut", int'(hBnOut), int'(!(mLvl[2] ^ hBInv)));
    chk("R8", "sampRefStrobe", int'(refStb), int'(mRef));
    chk("R8", "sampDataStrobe", int'(dataStb), int'(mData));
  endtask

  task automatic runCycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checkAll();
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    // R9 reset state, with inversion applied to show R6 during reset
    rgRise = 6'd3; rgFall = 6'd20; refCode = 6'd0; dataCode = 6'd1;
    repeat (3) @(negedge clk);
    chk("R9", "phaseOut reset", int'(phaseOut), 0);
    chk("R9", "rgOut reset", int'(rgOut), 0);
    chk("R9", "strobes reset", int'(refStb) + int'(dataStb), 0);
    rgInv = 1'b1; hAInv = 1'b1;
    #1;
    chk("R6", "rgOut inverted in reset", int'(rgOut), 1);
    chk("R7", "hAnOut in reset", int'(hAnOut), 0);
    rgInv = 1'b0; hAInv = 1'b0;
    rstN = 1'b1;
    runCycles(100);

    // sweep all rising codes against spread falling codes
    for (int r = 0; r < 64; r++) begin
      for (int fk = 0; fk < 16; fk++) begin
        @(negedge clk);
        rgRise = 6'(r);             rgFall = 6'((r + fk * 4 + 1) % 64);
        hARise = 6'((r + fk * 4 + 1) % 64); hAFall = 6'(r);
        hBRise = 6'(r ^ 6'h2a);      hBFall = 6'((r * 5 + fk * 3) % 64);
        refCode = 6'(r);            dataCode = 6'((fk * 7 + r) % 64);
        rgInv = fk[0]; hAInv = fk[1]; hBInv = r[0];
        #1;
        checkAll();
        runCycles(49);
      end
    end

    // R5: equal rise and fall codes hold a known level
    for (int e = 0; e < 64; e++) begin
      @(negedge clk);
      rgRise = 6'd2; rgFall = 6'd40; hARise = 6'd40; hAFall = 6'd2;
      rgInv = e[0]; hAInv = 1'b0;
      #1;
      checkAll();
      runCycles(48);
      @(negedge clk);
      rgRise = 6'(e); rgFall = 6'(e);
      hARise = 6'(e); hAFall = 6'(e);
      #1;
      checkAll();
      runCycles(49);
    end

    finished = 1;
    finishRun();
  end
endmodule